// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers interrupt requests for a processor core and decides which one the core should take next. Two kinds of source feed it. The core's own system exceptions arrive on a 16-bit pulse vector indexed by exception number. Peripheral lines arrive on a parameterized pulse vector, and line n is exception number 16+n. Every pulse latches a pending bit. The controller then selects the most urgent pending source that is also enabled. Its exception number and its vector fetch address (the number times four) are presented to the core whenever that source may preempt the handler now running.

Reset, the non-maskable interrupt and hard fault sit at three fixed urgency levels above every programmable one. Every other implemented source has a 3-bit priority value, and a smaller value means more urgent. Peripheral enables are changed only through write-one-to-set and write-one-to-clear register banks. The core confirms that it takes a request with an accept strobe and marks the end of a handler with a completion strobe. The controller keeps a set of active exceptions, so nested handlers unwind in order, and it reports which exception is running.

Top module: `ivc_top`

## Requirements
- R1: After reset, irq_req is 0, act_num is 0, all peripheral enables read 0 and all programmable priorities read 0.
- R2: Peripheral line n is presented as exception number 16+n. Whenever irq_req is 1, irq_vec equals irq_num multiplied by 4.
- R3: Exception 1 (reset) beats 2 (NMI), which beats 3 (hard fault), and all three beat any programmable source, even one at priority 0.
- R4: Among programmable sources, the smaller priority value wins.
- R5: When two pending sources have equal urgency, the one with the lower exception number wins.
- R6: Writing a 1 to a bit of set-enable bank b (address 0x000+b, bit i means line 32b+i) enables that line, and writing a 0 there has no effect. Reading the set-enable address or the clear-enable address of a bank returns the current enable bits.
- R7: Writing a 1 to a bit of clear-enable bank b (address 0x008+b) disables that line.
- R8: A disabled line still latches its pending bit but is never presented. Enabling it later presents it.
- R9: A source is presented only when it is strictly more urgent than the running exception. An equally urgent or less urgent source waits for irq_eoi.
- R10: When irq_ack is high while irq_req is high, the presented exception becomes the running one (act_num), its pending bit clears, and irq_req is 0 in the cycle after. irq_eoi retires the running exception and exposes the one it preempted.
- R11: irq_req and irq_num change one clock after the pending or enable state changes. A pulse sampled at edge k is therefore presented after edge k+1.
- R12: The priority of exception k is at address 0x100+k, in bits [2:0]. Only programmable exceptions (4, 5, 6, 11, 12, 14, 15 and all peripherals) store writes. For the others, reads return 0 and writes are ignored.
- R13: Pulses on exception numbers 0, 7, 8, 9, 10 and 13 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sys_req | input | 16 | System exception request pulses, bit k = exception number k |
| irq_in | input | NUM_IRQ | Peripheral request pulses, bit n = exception 16+n |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rd | input | 1 | Configuration read strobe (data valid after the next edge) |
| cfg_addr | input | 9 | Configuration word address |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Registered configuration read data |
| irq_req | output | 1 | A source is being presented to the core |
| irq_num | output | 8 | Exception number of the presented source |
| irq_vec | output | 10 | Vector fetch byte address of the presented source |
| irq_ack | input | 1 | Core accepts the presented source |
| irq_eoi | input | 1 | Running handler has completed |
| act_num | output | 8 | Exception number of the running handler, 0 when none |

## Verification
The hardest situation to reach is a nested stack in which a pending source is blocked by equal urgency. Once the handler above it finishes, the same source must become presentable without any new request. The stimulus builds this directly. It accepts one handler, pulses a more urgent line to nest a second, and then pulses a line whose priority equals the running one. It then retires handlers one at a time with irq_eoi, checking act_num and the presented number after each step. The fixed-level sources receive the same treatment, with a reset-level pulse arriving while a hard fault is running.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
  // width of an exception number
  localparam int EXC_W = 8;
  // count of system exception slots below the first peripheral
  localparam int SYS_N = 16;
  // implemented system exception numbers: 1..6, 11, 12, 14, 15
  localparam logic [15:0] SYS_IMPL = 16'hD87E;

  // urgency fixed above all programmable levels
  function automatic bit is_fixed(int k);
    return (k >= 1) && (k <= 3);
  endfunction

  // priority held in a register
  function automatic bit is_prog(int k);
    if (k >= SYS_N) return 1'b1;
    if (k >= 4) return SYS_IMPL[k];
    return 1'b0;
  endfunction

  // vector fetch byte address: one word per exception number
  function automatic logic [EXC_W+1:0] vec_addr(logic [EXC_W-1:0] n);
    return {n, 2'b00};
  endfunction
endpackage

// File: rtl/ivc_arb.sv
// Picks the candidate with the smallest urgency key, lower index on ties.
module ivc_arb #(
  parameter int N     = 80,
  parameter int KEY_W = 4,
  parameter int NUM_W = 8
) (
  input  logic [N-1:0]            cand,
  input  logic [N-1:0][KEY_W-1:0] key,
  output logic                    found,
  output logic [NUM_W-1:0]        best_num,
  output logic [KEY_W-1:0]        best_key
);
  always_comb begin
    found    = 1'b0;
    best_num = '0;
    best_key = '1;
    for (int k = 0; k < N; k++) begin
      if (cand[k] && (!found || (key[k] < best_key))) begin
        found    = 1'b1;
        best_num = NUM_W'(k);
        best_key = key[k];
      end
    end
  end
endmodule

// File: rtl/ivc_cfg.sv
// Enable banks, priority registers, urgency keys and the read port.
module ivc_cfg
  import ivc_pkg::*;
#(
  parameter int NUM_IRQ = 64,
  parameter int NUM_EXC = 80,
  parameter int PRIO_W  = 3,
  parameter int KEY_W   = 4,
  parameter int AW      = 9,
  parameter int DW      = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr,
  input  logic                          rd,
  input  logic [AW-1:0]                 addr,
  input  logic [DW-1:0]                 wdata,
  output logic [DW-1:0]                 rdata,
  output logic [NUM_IRQ-1:0]            irq_en,
  output logic [NUM_EXC-1:0][KEY_W-1:0] urg_key
);
  localparam int BANK_W  = 3;
  localparam int KEY_OFS = 3;

  logic [NUM_IRQ-1:0]            en_q;
  logic [NUM_EXC-1:0][PRIO_W-1:0] prio_rd;
  logic [DW-1:0]                 rd_n;

  // addr[8]=0, addr[7:4]=0: enable banks; addr[3] picks clear over set
  wire en_sel   = wr && !addr[AW-1] && (addr[7:4] == 4'd0);
  wire prio_sel = wr && addr[AW-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (en_sel) begin
      for (int i = 0; i < NUM_IRQ; i++) begin
        if ((addr[BANK_W-1:0] == BANK_W'(i / DW)) && wdata[i % DW])
          en_q[i] <= !addr[3];
      end
    end
  end
  assign irq_en = en_q;

  for (genvar k = 0; k < NUM_EXC; k++) begin : g_src
    if (is_prog(k)) begin : g_prog
      logic [PRIO_W-1:0] p_q;
      always_ff @(posedge clk) begin
        if (!rst_n) p_q <= '0;
        else if (prio_sel && (addr[7:0] == 8'(k))) p_q <= wdata[PRIO_W-1:0];
      end
      assign prio_rd[k] = p_q;
      assign urg_key[k] = KEY_W'(p_q) + KEY_W'(KEY_OFS);
    end else if (is_fixed(k)) begin : g_fixed
      assign prio_rd[k] = '0;
      assign urg_key[k] = KEY_W'(k - 1);
    end else begin : g_none
      assign prio_rd[k] = '0;
      assign urg_key[k] = '1;
    end
  end

  always_comb begin
    rd_n = '0;
    if (!addr[AW-1]) begin
      if (addr[7:4] == 4'd0) begin
        for (int i = 0; i < NUM_IRQ; i++)
          if (addr[BANK_W-1:0] == BANK_W'(i / DW)) rd_n[i % DW] = en_q[i];
      end
    end else begin
      for (int k = 0; k < NUM_EXC; k++)
        if (addr[7:0] == 8'(k)) rd_n[PRIO_W-1:0] = prio_rd[k];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata <= '0;
    else if (rd) rdata <= rd_n;
  end
endmodule

// File: rtl/ivc_top.sv
module ivc_top
  import ivc_pkg::*;
#(
  parameter int NUM_IRQ = 64,
  parameter int PRIO_W  = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [15:0]          sys_req,
  input  logic [NUM_IRQ-1:0]   irq_in,
  input  logic                 cfg_wr,
  input  logic                 cfg_rd,
  input  logic [8:0]           cfg_addr,
  input  logic [31:0]          cfg_wdata,
  output logic [31:0]          cfg_rdata,
  output logic                 irq_req,
  output logic [7:0]           irq_num,
  output logic [9:0]           irq_vec,
  input  logic                 irq_ack,
  input  logic                 irq_eoi,
  output logic [7:0]           act_num
);
  localparam int NUM_EXC = SYS_N + NUM_IRQ;
  localparam int KEY_W   = $clog2((1 << PRIO_W) + 4);

  logic [NUM_IRQ-1:0]            irq_en;
  logic [NUM_EXC-1:0][KEY_W-1:0] urg_key;
  logic [NUM_EXC-1:0]            req_all, en_all, pend, active;
  logic [NUM_EXC-1:0]            acc_mask, eoi_mask;

  logic             sel_found, run_found;
  logic [EXC_W-1:0] sel_num, run_num;
  logic [KEY_W-1:0] sel_key, run_key;

  logic             req_q;
  logic [EXC_W-1:0] num_q;
  logic [KEY_W-1:0] key_q;

  // named events for the checker
  wire acc_fire = irq_ack && req_q;
  wire ret_fire = irq_eoi && run_found;

  ivc_cfg #(
    .NUM_IRQ(NUM_IRQ), .NUM_EXC(NUM_EXC), .PRIO_W(PRIO_W), .KEY_W(KEY_W),
    .AW(9), .DW(32)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .rd(cfg_rd), .addr(cfg_addr),
    .wdata(cfg_wdata), .rdata(cfg_rdata), .irq_en(irq_en), .urg_key(urg_key)
  );

  for (genvar k = 0; k < NUM_EXC; k++) begin : g_map
    if (k < SYS_N) begin : g_sys
      assign req_all[k] = sys_req[k] & SYS_IMPL[k];
      assign en_all[k]  = SYS_IMPL[k];
    end else begin : g_per
      assign req_all[k] = irq_in[k-SYS_N];
      assign en_all[k]  = irq_en[k-SYS_N];
    end
  end

  ivc_arb #(.N(NUM_EXC), .KEY_W(KEY_W), .NUM_W(EXC_W)) u_sel (
    .cand(pend & en_all), .key(urg_key),
    .found(sel_found), .best_num(sel_num), .best_key(sel_key)
  );

  ivc_arb #(.N(NUM_EXC), .KEY_W(KEY_W), .NUM_W(EXC_W)) u_run (
    .cand(active), .key(urg_key),
    .found(run_found), .best_num(run_num), .best_key(run_key)
  );

  assign acc_mask = acc_fire ? (NUM_EXC'(1) << num_q) : '0;
  assign eoi_mask = ret_fire ? (NUM_EXC'(1) << run_num) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend   <= '0;
      active <= '0;
    end else begin
      pend   <= (pend & ~acc_mask) | req_all;
      active <= (active & ~eoi_mask) | acc_mask;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      num_q <= '0;
      key_q <= '1;
    end else begin
      req_q <= !acc_fire && sel_found && (sel_key < run_key);
      num_q <= sel_num;
      key_q <= sel_key;
    end
  end

  assign irq_req = req_q;
  assign irq_num = num_q;
  assign irq_vec = vec_addr(num_q);
  assign act_num = run_found ? run_num : '0;
endmodule

// File: rtl/ivc_top_chk.sv
module ivc_top_chk #(
  parameter int KEY_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq_req,
  input logic [7:0]       irq_num,
  input logic [9:0]       irq_vec,
  input logic             acc_fire,
  input logic [7:0]       act_num,
  input logic [KEY_W-1:0] req_key,
  input logic [KEY_W-1:0] run_key
);
  a_r10_req_drops: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fire |=> !irq_req);

  a_r10_becomes_running: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fire |=> (act_num == $past(irq_num)));

  a_r9_strict_preempt: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (req_key < run_key));

  a_r2_vector_word: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> ((irq_vec[1:0] == 2'b00) && (irq_vec != '0) && (irq_num != '0)));

  a_r13_no_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> !(irq_num inside {8'd7, 8'd8, 8'd9, 8'd10, 8'd13}));
endmodule

bind ivc_top ivc_top_chk #(.KEY_W(KEY_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_num(irq_num),
  .irq_vec(irq_vec), .acc_fire(acc_fire), .act_num(act_num),
  .req_key(key_q), .run_key(run_key)
);

// File: tb/ivc_top_test.sv
`timescale 1ns/1ps
module ivc_top_test;
  localparam int NIRQ = 64;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [15:0]     sys_req = '0;
  logic [NIRQ-1:0] irq_in = '0;
  logic            cfg_wr = 1'b0, cfg_rd = 1'b0;
  logic [8:0]      cfg_addr = '0;
  logic [31:0]     cfg_wdata = '0;
  logic [31:0]     cfg_rdata;
  logic            irq_req;
  logic [7:0]      irq_num;
  logic [9:0]      irq_vec;
  logic            irq_ack = 1'b0, irq_eoi = 1'b0;
  logic [7:0]      act_num;

  int total = 0;
  int bad = 0;
  bit done = 0;

  typedef struct { bit req; int num; string tag; } exp_t;
  exp_t sb[$];

  always #10 clk = ~clk;

  ivc_top #(.NUM_IRQ(NIRQ), .PRIO_W(3)) uut (
    .clk(clk), .rst_n(rst_n), .sys_req(sys_req), .irq_in(irq_in),
    .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .irq_req(irq_req), .irq_num(irq_num), .irq_vec(irq_vec),
    .irq_ack(irq_ack), .irq_eoi(irq_eoi), .act_num(act_num)
  );

  // monitor: compares presented request against the scoreboard
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      total++;
      if (irq_req !== e.req ||
          (e.req && (irq_num !== 8'(e.num) || irq_vec !== 10'(e.num * 4)))) begin
        bad++;
        $display("FAIL %s: req=%0d num=%0d vec=%0d expected req=%0d num=%0d vec=%0d",
                 e.tag, irq_req, irq_num, irq_vec, e.req, e.num, e.num * 4);
      end
    end
  end

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic look(bit req, int num, string tag);
    exp_t e;
    e.req = req; e.num = num; e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
    #1;
  endtask

  task automatic check(string tag, int act, int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic wr(logic [8:0] a, logic [31:0] d);
    cfg_wr = 1; cfg_addr = a; cfg_wdata = d;
    tick();
    cfg_wr = 0;
  endtask

  task automatic rd(logic [8:0] a, int expv, string tag);
    cfg_rd = 1; cfg_addr = a;
    tick();
    cfg_rd = 0;
    check(tag, int'(cfg_rdata), expv);
  endtask

  task automatic pulse(logic [15:0] s, logic [NIRQ-1:0] p);
    sys_req = s; irq_in = p;
    tick();
    sys_req = '0; irq_in = '0;
  endtask

  task automatic ack();
    irq_ack = 1; tick(); irq_ack = 0;
  endtask

  task automatic eoi();
    irq_eoi = 1; tick(); irq_eoi = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: got hung expected finish");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    tick();

    // R1 reset state
    look(0, 0, "R1 no request");
    check("R1 act_num", act_num, 0);
    rd(9'h000, 0, "R1 enable bank0");
    rd(9'h104, 0, "R1 priority exc4");

    // R6 set-enable, zeros ignored, both addresses read state
    wr(9'h000, 32'h21);
    rd(9'h000, 32'h21, "R6 set bank0");
    wr(9'h000, 32'h0);
    rd(9'h000, 32'h21, "R6 zero write no effect");
    rd(9'h008, 32'h21, "R6 clear addr reads state");
    wr(9'h001, 32'h1);
    rd(9'h001, 32'h1, "R6 bank1 line32");

    // R7 clear-enable
    wr(9'h008, 32'h20);
    rd(9'h000, 32'h1, "R7 line5 cleared");

    // R8 disabled line keeps pending; R11 one-clock update after enable
    pulse('0, 64'h20);
    tick(); tick();
    look(0, 0, "R8 disabled not presented");
    wr(9'h000, 32'h20);
    look(0, 0, "R11 not yet after enable");
    tick();
    look(1, 21, "R8 R2 line5 is exc21");
    ack();
    look(0, 0, "R10 req drops after ack");
    check("R10 act_num", act_num, 21);
    eoi();
    check("R10 eoi retires", act_num, 0);
    tick(); tick();
    look(0, 0, "R10 pending cleared by ack");

    // R11 timing from a pulse
    pulse('0, 64'h1);
    look(0, 0, "R11 one clock after pend");
    tick();
    look(1, 16, "R11 R2 line0 presented");
    ack(); eoi(); tick();

    // R4 / R5 programmable ordering
    wr(9'h000, 32'h0E);
    wr(9'h111, 32'd5);
    wr(9'h112, 32'd2);
    wr(9'h113, 32'd2);
    pulse('0, 64'hE);
    tick(); tick();
    look(1, 18, "R4 R5 lower value, lower number");
    ack();
    check("R10 act 18", act_num, 18);
    tick();
    look(0, 0, "R9 equal waits");
    eoi(); tick();
    look(1, 19, "R9 equal presented after eoi");
    ack(); eoi(); tick(); tick();
    look(1, 17, "R4 least urgent last");
    ack(); eoi(); tick(); tick();
    look(0, 0, "R10 all served");

    // R9 nesting
    pulse('0, 64'h2);
    tick();
    look(1, 17, "R9 base handler");
    ack();
    check("R9 act 17", act_num, 17);
    pulse('0, 64'h4);
    tick();
    look(1, 18, "R9 strictly more urgent preempts");
    ack();
    check("R9 act 18 nested", act_num, 18);
    pulse('0, 64'h8);
    tick(); tick();
    look(0, 0, "R9 equal to running blocked");
    eoi();
    check("R10 unwinds to 17", act_num, 17);
    tick();
    look(1, 19, "R9 blocked source presented");
    ack();
    check("R9 act 19", act_num, 19);
    eoi();
    check("R10 back to 17", act_num, 17);
    eoi();
    check("R10 idle", act_num, 0);

    // R3 fixed levels and R5 tie
    wr(9'h104, 32'd0);
    pulse(16'h001C, 64'h8);
    tick();
    look(1, 2, "R3 NMI first");
    ack();
    check("R3 act NMI", act_num, 2);
    tick(); tick();
    look(0, 0, "R3 hard fault below NMI");
    eoi(); tick();
    look(1, 3, "R3 hard fault next");
    ack();
    pulse(16'h0002, '0);
    tick();
    look(1, 1, "R3 reset preempts hard fault");
    ack();
    check("R3 act reset", act_num, 1);
    eoi();
    check("R3 back to hard fault", act_num, 3);
    eoi();
    check("R3 idle", act_num, 0);
    wr(9'h113, 32'd0);
    tick();
    look(1, 4, "R5 tie lower number");
    ack(); eoi(); tick(); tick();
    look(1, 19, "R5 tie other after");
    ack(); eoi(); tick(); tick();
    look(0, 0, "R3 all served");

    // R12 priority register access
    wr(9'h104, 32'd6);
    rd(9'h104, 6, "R12 prog readback");
    wr(9'h105, 32'hFF);
    rd(9'h105, 7, "R12 field is 3 bits");
    wr(9'h102, 32'd5);
    rd(9'h102, 0, "R12 fixed reads 0");
    wr(9'h107, 32'd3);
    rd(9'h107, 0, "R12 reserved reads 0");

    // R13 reserved numbers ignored
    pulse(16'h2781, '0);
    tick(); tick();
    look(0, 0, "R13 reserved pulses ignored");
    check("R13 act stays 0", act_num, 0);

    tick();
    summary();
  end
endmodule